// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block collects the interrupt conditions of a PC-style serial port and produces the interrupt identification byte and the interrupt request line. It accepts five sources: receive line errors, receive data available (or trigger level reached), character timeout, transmit holding register empty, and modem status change. Each source is masked by its bit in the interrupt enable value. The highest-priority unmasked pending source is encoded into the identification byte. The request line is asserted only while the auxiliary-output-2 control bit is set.

Each source is cleared by the access that services it. Line errors clear on a line status read. Modem changes clear on a modem status read. Receive data and timeout clear through receive buffer reads. Transmit-empty clears on a holding register write, or on an identification read that reported it. The character timeout is timed inside the block from receive FIFO activity strobes. The identification byte and the request line are registered, so the host reads settled values.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `iir_o` is 0x01 and `irq_o` is 0.
- R2: Priority from highest to lowest is line status, then receive data or timeout (receive data first), then transmit-empty, then modem status.
- R3: `iir_o[3:1]` encodes the reported source: 011 line status, 010 receive data, 110 timeout, 001 transmit-empty, 000 modem status. `iir_o[0]` is 0 when a source is pending and 1 otherwise. `iir_o[5:4]` are 0.
- R4: `ier_i` bit 0 enables receive data and timeout, bit 1 transmit-empty, bit 2 line status, and bit 3 modem status. A masked source is never reported, but its latched state is kept.
- R5: `irq_o` equals the pending indication of `iir_o` gated by `aux2_i`. `aux2_i` does not change `iir_o`.
- R6: A `lsr_evt_i` pulse latches a line status interrupt. A `rd_lsr_i` pulse clears it.
- R7: A `msr_evt_i` pulse latches a modem status interrupt. A `rd_msr_i` pulse clears it.
- R8: The transmit-empty interrupt is cleared by `wr_thr_i`, or by `rd_iir_i` while `iir_o` reports transmit-empty.
- R9: The transmit-empty interrupt arms on a rising edge of `thr_empty_i`, or on a rising edge of `ier_i[1]` while `thr_empty_i` is high.
- R10: With `fifo_en_i` high, timeout arms after 4×`CHAR_CYCLES` cycles in which the receive FIFO is non-empty and has seen no push or read. A push, a read, or an empty FIFO clears the timeout and restarts the timer.
- R11: `iir_o[7:6]` read 11 when `fifo_en_i` is high and 00 when it is low.
- R12: An `rd_iir_i` pulse while another source is reported leaves a pending transmit-empty interrupt intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Interrupt enable bits |
| aux2_i | input | 1 | Auxiliary output 2 control bit, gates the request |
| fifo_en_i | input | 1 | FIFO mode enabled |
| lsr_evt_i | input | 1 | Pulse: receive line error detected |
| rd_lsr_i | input | 1 | Pulse: line status register read |
| msr_evt_i | input | 1 | Pulse: modem status input changed |
| rd_msr_i | input | 1 | Pulse: modem status register read |
| rx_avail_i | input | 1 | Level: receive data available or trigger reached |
| rx_nonempty_i | input | 1 | Level: receive FIFO holds at least one byte |
| rx_push_i | input | 1 | Pulse: byte written into receive FIFO |
| rd_rbr_i | input | 1 | Pulse: receive buffer read |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| wr_thr_i | input | 1 | Pulse: transmit holding register write |
| rd_iir_i | input | 1 | Pulse: identification register read |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench stacks several sources at once and removes them one at a time. A wrong priority order or a wrong identity code would report the wrong byte at some step. An identification read is issued while line status is on top and transmit-empty is pending underneath. A design that clears transmit-empty on every identification read would then drop to 0xC1 instead of 0xC2 once line status is read. The timeout is probed just before and after four character times, and across repeated pushes. A timer that is off by a character, or that ignores pushes, fires at the wrong check point. Masking and output gating are exercised separately, so that a mask that also discards latched state shows up.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6 R7
  latch_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R6 R7
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty_i,
  input  logic en_i,
  input  logic wr_thr_i,
  input  logic rd_clr_i,
  output logic flag_o
);
  logic empty_q, en_q, arm;

  assign arm = thr_empty_i && (!empty_q || (en_i && !en_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      en_q    <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      empty_q <= thr_empty_i;
      en_q    <= en_i;
      if (arm)                       flag_o <= 1'b1;
      else if (wr_thr_i || rd_clr_i) flag_o <= 1'b0;
    end
  end

  // R9
  thre_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty_i) |=> flag_o);
  // R8
  thre_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_thr_i && !thr_empty_i) |=> !flag_o);
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int CHAR_CYCLES = 16,
  parameter int TO_CHARS    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_en_i,
  input  logic nonempty_i,
  input  logic push_i,
  input  logic pop_i,
  output logic to_o
);
  localparam int LIMIT = CHAR_CYCLES * TO_CHARS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          idle_break;

  assign idle_break = push_i || pop_i || !nonempty_i || !fifo_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      to_o <= 1'b0;
    end else if (idle_break) begin
      cnt  <= '0;
      to_o <= 1'b0;
    end else if (!to_o) begin
      if (cnt == CW'(LIMIT - 1)) begin
        cnt  <= '0;
        to_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  to_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(to_o) |-> ($past(nonempty_i) && $past(fifo_en_i)));
  // R10
  to_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |=> !to_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic    line_i,
  input  logic    rx_i,
  input  logic    to_i,
  input  logic    thre_i,
  input  logic    modem_i,
  output logic    pend_o,
  output irq_id_e id_o
);
  always_comb begin
    pend_o = 1'b1;
    id_o   = ID_MODEM;
    if (line_i)       id_o = ID_LINE;
    else if (rx_i)    id_o = ID_RXDATA;
    else if (to_i)    id_o = ID_TIMEOUT;
    else if (thre_i)  id_o = ID_THRE;
    else if (modem_i) id_o = ID_MODEM;
    else              pend_o = 1'b0;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CHAR_CYCLES = 16,
  parameter int TO_CHARS    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ier_i,
  input  logic       aux2_i,
  input  logic       fifo_en_i,
  input  logic       lsr_evt_i,
  input  logic       rd_lsr_i,
  input  logic       msr_evt_i,
  input  logic       rd_msr_i,
  input  logic       rx_avail_i,
  input  logic       rx_nonempty_i,
  input  logic       rx_push_i,
  input  logic       rd_rbr_i,
  input  logic       thr_empty_i,
  input  logic       wr_thr_i,
  input  logic       rd_iir_i,
  output logic [7:0] iir_o,
  output logic       irq_o
);
  logic    line_q, modem_q, thre_q, to_q;
  logic    thre_rd_clr, pend;
  irq_id_e id;

  assign thre_rd_clr = rd_iir_i && !iir_o[0] && (iir_o[3:1] == ID_THRE);

  uart_irq_latch u_line (
    .clk(clk), .rst(rst), .set_i(lsr_evt_i), .clr_i(rd_lsr_i), .flag_o(line_q));

  uart_irq_latch u_modem (
    .clk(clk), .rst(rst), .set_i(msr_evt_i), .clr_i(rd_msr_i), .flag_o(modem_q));

  uart_irq_thre u_thre (
    .clk(clk), .rst(rst), .thr_empty_i(thr_empty_i), .en_i(ier_i[EN_THRE]),
    .wr_thr_i(wr_thr_i), .rd_clr_i(thre_rd_clr), .flag_o(thre_q));

  uart_irq_timeout #(.CHAR_CYCLES(CHAR_CYCLES), .TO_CHARS(TO_CHARS)) u_to (
    .clk(clk), .rst(rst), .fifo_en_i(fifo_en_i), .nonempty_i(rx_nonempty_i),
    .push_i(rx_push_i), .pop_i(rd_rbr_i), .to_o(to_q));

  uart_irq_prio u_prio (
    .line_i (line_q     && ier_i[EN_LINE]),
    .rx_i   (rx_avail_i && ier_i[EN_RX]),
    .to_i   (to_q       && ier_i[EN_RX]),
    .thre_i (thre_q     && ier_i[EN_THRE]),
    .modem_i(modem_q    && ier_i[EN_MODEM]),
    .pend_o (pend),
    .id_o   (id));

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= 8'h01;
      irq_o <= 1'b0;
    end else begin
      iir_o <= {{2{fifo_en_i}}, 2'b00, id, !pend};
      irq_o <= pend && aux2_i;
    end
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(aux2_i) && !iir_o[0]));
  // R3
  id_legal_chk: assert property (@(posedge clk) disable iff (rst)
    !iir_o[0] |-> (iir_o[3:1] != 3'b100 && iir_o[3:1] != 3'b101 && iir_o[3:1] != 3'b111));
  // R4
  line_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!iir_o[0] && iir_o[3:1] == 3'b011) |-> $past(ier_i[2]));
  // R11
  fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (iir_o[7:6] == 2'b11) |-> $past(fifo_en_i));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int CHARS      = 16;

  typedef struct packed {
    logic [3:0] ier;
    logic       aux2, fifo, thr_e, rxa, lse, mse, rdl, rdm, rdi, wrt;
    logic [7:0] exp_iir;
    logic       exp_irq;
    logic [3:0] req;
  } vec_t;

  // steps are cumulative: latched sources persist between rows
  localparam vec_t TBL [21] = '{
    '{4'b0000,1,0,1,0,0,0,0,0,0,0,8'h01,0,4},  // R4 nothing enabled
    '{4'b0010,1,0,1,0,0,0,0,0,0,0,8'h02,1,9},  // R9 enable rise while empty
    '{4'b0010,1,0,1,0,0,0,0,0,1,0,8'h01,0,8},  // R8 iir read clears thre
    '{4'b0011,1,0,1,1,0,0,0,0,0,0,8'h04,1,3},  // R3 rx data
    '{4'b0111,1,0,1,1,1,0,0,0,0,0,8'h06,1,2},  // R2 line over rx
    '{4'b1111,1,0,1,1,0,1,0,0,0,0,8'h06,1,2},  // R2 line over modem
    '{4'b1111,1,0,1,1,0,0,1,0,0,0,8'h04,1,6},  // R6 lsr read clears
    '{4'b1111,1,0,1,0,0,0,0,0,0,0,8'h00,1,7},  // R7 modem reported
    '{4'b1111,0,0,1,0,0,0,0,0,0,0,8'h00,0,5},  // R5 aux2 gates irq
    '{4'b1111,1,0,1,0,0,0,0,1,0,0,8'h01,0,7},  // R7 msr read clears
    '{4'b1111,1,0,0,0,0,0,0,0,0,0,8'h01,0,9},  // R9 holding full
    '{4'b1111,1,0,1,0,0,0,0,0,0,0,8'h02,1,9},  // R9 empty edge arms
    '{4'b1111,1,0,1,0,0,0,0,0,0,1,8'h01,0,8},  // R8 write clears
    '{4'b1111,1,1,1,0,0,0,0,0,0,0,8'hC1,0,11}, // R11 fifo bits
    '{4'b0011,1,1,1,0,1,0,0,0,0,0,8'hC1,0,4},  // R4 line masked
    '{4'b0111,1,1,1,0,0,0,0,0,0,0,8'hC6,1,4},  // R4 latched state kept
    '{4'b0111,1,1,0,0,0,0,0,0,0,0,8'hC6,1,2},
    '{4'b0111,1,1,1,0,0,0,0,0,0,0,8'hC6,1,2},  // R2 line over thre
    '{4'b0111,1,1,1,0,0,0,0,0,1,0,8'hC6,1,12}, // R12 iir read, line shown
    '{4'b0111,1,1,1,0,0,0,1,0,0,0,8'hC2,1,12}, // R12 thre survived
    '{4'b0111,1,1,1,0,0,0,0,0,1,0,8'hC1,0,8}   // R8
  };

  logic clk = 0, rst = 1;
  logic [3:0] ier = 0;
  logic aux2 = 0, fifo = 0, lse = 0, rdl = 0, mse = 0, rdm = 0, rxa = 0;
  logic rxne = 0, push = 0, rdr = 0, thr_e = 0, wrt = 0, rdi = 0;
  logic [7:0] iir;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.CHAR_CYCLES(CHARS)) dut (
    .clk(clk), .rst(rst), .ier_i(ier), .aux2_i(aux2), .fifo_en_i(fifo),
    .lsr_evt_i(lse), .rd_lsr_i(rdl), .msr_evt_i(mse), .rd_msr_i(rdm),
    .rx_avail_i(rxa), .rx_nonempty_i(rxne), .rx_push_i(push), .rd_rbr_i(rdr),
    .thr_empty_i(thr_e), .wr_thr_i(wrt), .rd_iir_i(rdi),
    .iir_o(iir), .irq_o(irq));

  task automatic check(input string tag, input logic [7:0] ei, input logic eq);
    checks++;
    if (iir !== ei || irq !== eq) begin
      fails++;
      $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b", tag, iir, irq, ei, eq);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_push();
    push = 1; @(negedge clk); push = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 in reset", 8'h01, 0);
    @(negedge clk); rst = 0;
    check("R1 first cycle after reset", 8'h01, 0);

    for (int s = 0; s < 21; s++) begin
      ier = TBL[s].ier; aux2 = TBL[s].aux2; fifo = TBL[s].fifo;
      thr_e = TBL[s].thr_e; rxa = TBL[s].rxa;
      lse = TBL[s].lse; mse = TBL[s].mse; rdl = TBL[s].rdl;
      rdm = TBL[s].rdm; rdi = TBL[s].rdi; wrt = TBL[s].wrt;
      @(negedge clk);
      lse = 0; mse = 0; rdl = 0; rdm = 0; rdi = 0; wrt = 0;
      idle(3);
      check($sformatf("R%0d table step %0d", TBL[s].req, s), TBL[s].exp_iir, TBL[s].exp_irq);
    end

    // R10: timeout with rx enabled, fifo on, thre masked
    ier = 4'b0001; fifo = 1; aux2 = 1; rxa = 0;
    rxne = 1; pulse_push();
    idle(58);
    check("R10 no timeout before four chars", 8'hC1, 0);
    idle(12);
    check("R10 timeout after four chars", 8'hCC, 1);
    rxa = 1; idle(2);
    check("R2 rx data over timeout", 8'hC4, 1);
    rxa = 0;
    rdr = 1; @(negedge clk); rdr = 0; idle(2);
    check("R10 read clears timeout", 8'hC1, 0);
    for (int k = 0; k < 3; k++) begin
      idle(40); pulse_push();
    end
    idle(2);
    check("R10 pushes restart timer", 8'hC1, 0);
    rxne = 0; idle(100);
    check("R10 empty fifo never times out", 8'hC1, 0);

    // R11: fifo off drops bits 7:6
    fifo = 0; idle(2);
    check("R11 no fifo", 8'h01, 0);

    // R1: reset with sources latched
    ier = 4'b1111; lse = 1; @(negedge clk); lse = 0; idle(2);
    check("R6 line latched before reset", 8'h06, 1);
    rst = 1; idle(2);
    check("R1 reset clears outputs", 8'h01, 0);
    ier = 4'b0000; @(negedge clk); rst = 0; ier = 4'b0100; idle(3);
    check("R1 reset cleared line latch", 8'h01, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule